// File: doc/BRIEF.md
# Keyed-Start Watchdog Timer

This block is a hardware watchdog that sits on the special-function-register write bus of an 8-bit microcontroller core. Software cannot start or restart it with an ordinary write. It must write two fixed key bytes in a row to the restart register, and only while the keyed-start configuration input is high. A valid key sets the enable flag, clears the interval counters and begins a new timeout interval. After that, the core has to repeat the key before the interval runs out.

The interval is counted in core cycle ticks. A 3-bit scale field in the control register selects a prescale factor that is a power of two, from 1 to 128. This factor multiplies the range of a base counter, which is 2^BASE_W ticks (14 bits by default). When the interval ends, the block raises a single-cycle reset request, clears its counters and clears the enable flag. The control register can be read back at any time. Its bit 0 always shows the live enable state.

Top module: `kwdt_top`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x00 and `rst_req` is low. The watchdog is stopped and the last recorded restart-register byte is 0x00.
- R2: A write of 0xE1 to address 0xA6 starts the watchdog when two conditions hold: `key_en` is high, and the previous recorded write to 0xA6 was 0x1E. Writes to other addresses do not break the pair. From the next cycle, `ctl_rdata[0]` reads 1 and both interval counters start from zero.
- R3: Any other write to 0xA6 leaves the enable state and the interval count unchanged. This includes 0x1E alone, 0xE1 after a different byte, and any other value.
- R4: While `key_en` is low, writes to 0xA6 are ignored completely. They start nothing and are not recorded as the previous byte.
- R5: A write to 0xA7 stores data bits 7..1, which read back on `ctl_rdata[7:1]` from the next cycle. The written bit 0 is ignored. Bits 7..5 form the scale field `ps`.
- R6: Once started, the timeout is reached on the 2^BASE_W × 2^ps-th cycle with `tick` high. Cycles with `tick` low do not count.
- R7: `rst_req` is high for exactly one cycle, the cycle after the edge that took the final tick. That same edge clears `ctl_rdata[0]` and the counters.
- R8: A valid key while the watchdog is running restarts a full interval from zero.
- R9: If a valid key arrives in the same cycle as the final tick, the restart wins. No reset request is raised and the enable stays set.
- R10: While stopped, the block never raises `rst_req`, however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_en | input | 1 | Configuration input that allows keyed start |
| tick | input | 1 | One instruction-cycle tick |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register write address |
| sfr_wdata | input | 8 | Register write data |
| ctl_rdata | output | 8 | Control register value; bit 0 is the live enable |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
Every result is due one clock edge after the stimulus that causes it:
- A control write or a key write shows on `ctl_rdata` one edge later.
- The edge that samples the final tick sets `rst_req` and clears the enable, so the request is visible before the next edge.

The bench drives and samples on the falling edge. Each register write occupies one full cycle. The tick task records `rst_req` on every falling edge it spends. Because of this, a request that arrives one tick early or late shows up as a wrong tick position, not merely as a missing pulse. The bench uses a 4-bit base counter, which keeps the longest interval (scale 7) at 2048 ticks.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int unsigned KWDT_PS_W   = 3;
  localparam int unsigned KWDT_SPARE_W = 8 - KWDT_PS_W - 1;

  typedef struct packed {
    logic [KWDT_PS_W-1:0]    ps;
    logic [KWDT_SPARE_W-1:0] spare;
  } kwdt_cfg_t;

endpackage

// File: rtl/kwdt_key_seq.sv
module kwdt_key_seq #(
  parameter logic [7:0] KEY_A = 8'h1E,
  parameter logic [7:0] KEY_B = 8'hE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_en,
  input  logic       wr_rst,
  input  logic [7:0] wdata,
  output logic       restart
);

  logic [7:0] last_q;
  logic [7:0] last_d;
  logic       take;

  always_comb begin
    take    = wr_rst & key_en;
    restart = take & (wdata == KEY_B) & (last_q == KEY_A);
    last_d  = take ? wdata : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (take) begin
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/kwdt_ctl_reg.sv
module kwdt_ctl_reg
  import kwdt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctl,
  input  logic [7:0]           wdata,
  input  logic                 set_en,
  input  logic                 clr_en,
  output logic [KWDT_PS_W-1:0] ps,
  output logic                 en,
  output logic [7:0]           rdata
);

  kwdt_cfg_t cfg_q, cfg_d;
  logic      en_q, en_d;

  always_comb begin
    cfg_d = wr_ctl ? kwdt_cfg_t'(wdata[7:1]) : cfg_q;
    if (set_en)      en_d = 1'b1;
    else if (clr_en) en_d = 1'b0;
    else             en_d = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_ctl) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (set_en | clr_en) begin
      en_q <= en_d;
    end
  end

  always_comb begin
    ps    = cfg_q.ps;
    en    = en_q;
    rdata = {cfg_q, en_q};
  end

endmodule

// File: rtl/kwdt_interval.sv
module kwdt_interval #(
  parameter int unsigned BASE_W = 14,
  parameter int unsigned PS_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic            tick,
  input  logic [PS_W-1:0] ps,
  output logic            expire
);

  localparam int unsigned PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0]  pre_q, pre_d, pre_lim;
  logic [BASE_W-1:0] base_q, base_d;
  logic              pre_wrap, step, clear, adv;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      pre_lim[i] = (i < int'(ps));
    end
  end

  always_comb begin
    adv      = run & tick;
    pre_wrap = (pre_q >= pre_lim);
    step     = adv & pre_wrap;
    expire   = step & (&base_q);
    clear    = restart | expire;
    if (clear) begin
      pre_d  = '0;
      base_d = '0;
    end else begin
      pre_d  = pre_wrap ? '0 : pre_q + 1'b1;
      base_d = step ? base_q + 1'b1 : base_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      base_q <= '0;
    end else if (clear | adv) begin
      pre_q  <= pre_d;
      base_q <= base_d;
    end
  end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned BASE_W   = 14,
  parameter logic [7:0]  RST_ADDR = 8'hA6,
  parameter logic [7:0]  CTL_ADDR = 8'hA7,
  parameter logic [7:0]  KEY_A    = 8'h1E,
  parameter logic [7:0]  KEY_B    = 8'hE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_en,
  input  logic       tick,
  input  logic       sfr_we,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] ctl_rdata,
  output logic       rst_req
);

  logic                 wr_rst, wr_ctl, restart, expire, en, req_d, req_q;
  logic [KWDT_PS_W-1:0] ps;

  always_comb begin
    wr_rst = sfr_we & (sfr_addr == RST_ADDR);
    wr_ctl = sfr_we & (sfr_addr == CTL_ADDR);
    req_d  = expire & ~restart;
  end

  kwdt_key_seq #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk(clk), .rst_n(rst_n), .key_en(key_en), .wr_rst(wr_rst),
    .wdata(sfr_wdata), .restart(restart)
  );

  kwdt_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wdata(sfr_wdata),
    .set_en(restart), .clr_en(req_d), .ps(ps), .en(en), .rdata(ctl_rdata)
  );

  kwdt_interval #(.BASE_W(BASE_W), .PS_W(KWDT_PS_W)) u_ivl (
    .clk(clk), .rst_n(rst_n), .run(en), .restart(restart), .tick(tick),
    .ps(ps), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign rst_req = req_q;

endmodule

// File: rtl/kwdt_top_chk.sv
module kwdt_top_chk #(
  parameter logic [7:0] RST_ADDR = 8'hA6,
  parameter logic [7:0] CTL_ADDR = 8'hA7,
  parameter logic [7:0] KEY_B    = 8'hE1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       key_en,
  input logic       sfr_we,
  input logic [7:0] sfr_addr,
  input logic [7:0] sfr_wdata,
  input logic [7:0] ctl_rdata,
  input logic       rst_req
);

  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_req_clears_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !ctl_rdata[0]);

  assert_req_needs_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(ctl_rdata[0]));

  assert_ctl_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == CTL_ADDR) |=> (ctl_rdata[7:1] == $past(sfr_wdata[7:1])));

  assert_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_en && !ctl_rdata[0]) |=> !ctl_rdata[0]);

  assert_start_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rdata[0]) |-> $past(sfr_we && key_en && sfr_addr == RST_ADDR
                                  && sfr_wdata == KEY_B));

endmodule

bind kwdt_top kwdt_top_chk #(
  .RST_ADDR(RST_ADDR), .CTL_ADDR(CTL_ADDR), .KEY_B(KEY_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .key_en(key_en), .sfr_we(sfr_we),
  .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .ctl_rdata(ctl_rdata),
  .rst_req(rst_req)
);

// File: tb/kwdt_top_bench.sv
`timescale 1ns/1ps
module kwdt_top_bench;

  localparam int BW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_en = 1'b0;
  logic       tick = 1'b0;
  logic       sfr_we = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       rst_req;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  kwdt_top #(.BASE_W(BW)) u_kwdt_top (
    .clk(clk), .rst_n(rst_n), .key_en(key_en), .tick(tick), .sfr_we(sfr_we),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .ctl_rdata(ctl_rdata),
    .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic key();
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
  endtask

  // n ticks; returns number of requests seen and the tick index of the first
  task automatic ticks(input int n, output int seen, output int at);
    seen = 0; at = -1;
    for (int i = 1; i <= n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (rst_req) begin
        seen++;
        if (at < 0) at = i;
      end
    end
    tick = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctl after reset", ctl_rdata, 0);
    check("R1 req after reset", rst_req, 0);
  endtask

  task automatic t_stopped();
    int s, a;
    ticks(40, s, a);
    check("R10 no request while stopped", s, 0);
  endtask

  task automatic t_ctl();
    wr(8'hA7, 8'h5B);
    check("R5 readback bit0 ignored", ctl_rdata, 8'h5A);
    wr(8'hA7, 8'h00);
    check("R5 readback cleared", ctl_rdata, 0);
  endtask

  task automatic t_locked();
    int s, a;
    key_en = 1'b0;
    key();
    check("R4 key ignored when locked", ctl_rdata[0], 0);
    wr(8'hA6, 8'h1E);
    key_en = 1'b1;
    wr(8'hA6, 8'hE1);
    check("R4 locked write not recorded", ctl_rdata[0], 0);
    ticks(20, s, a);
    check("R4 no request", s, 0);
  endtask

  task automatic t_broken();
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h55); wr(8'hA6, 8'hE1);
    check("R3 broken pair", ctl_rdata[0], 0);
    wr(8'hA6, 8'hE1); wr(8'hA6, 8'hE1);
    check("R3 repeated second key", ctl_rdata[0], 0);
    wr(8'hA6, 8'h1E); wr(8'hA7, 8'h00); wr(8'hA6, 8'hE1);
    check("R2 other address keeps pair", ctl_rdata[0], 1);
  endtask

  task automatic t_timeout(input int psv);
    int s, a, n;
    n = (1 << BW) << psv;
    wr(8'hA7, 8'(psv << 5));
    key();
    check("R2 started", ctl_rdata[0], 1);
    ticks(n, s, a);
    check("R6 request position", a, n);
    check("R7 single request", s, 1);
    check("R7 enable cleared", ctl_rdata[0], 0);
    @(negedge clk);
    check("R7 request dropped", rst_req, 0);
    check("R7 scale kept", ctl_rdata[7:5], psv);
  endtask

  task automatic t_gaps();
    int s, a, tot;
    wr(8'hA7, 8'h00);
    key();
    tot = 0;
    for (int k = 0; k < 16; k++) begin
      ticks(1, s, a); tot += s;
      repeat (2) @(negedge clk);
    end
    check("R6 gapped ticks reach timeout", tot, 1);
  endtask

  task automatic t_restart();
    int s, a;
    wr(8'hA7, 8'h00);
    key();
    ticks(10, s, a);
    key();
    ticks(16, s, a);
    check("R8 full interval after restart", a, 16);
  endtask

  task automatic t_noise();
    int s, a;
    key();
    ticks(5, s, a);
    wr(8'hA6, 8'h33); wr(8'hA6, 8'h1E); wr(8'hA6, 8'h00);
    ticks(11, s, a);
    check("R3 stray writes keep count", a, 11);
  endtask

  task automatic t_race();
    int s, a;
    key();
    ticks(15, s, a);
    wr(8'hA6, 8'h1E);
    tick = 1'b1;
    wr(8'hA6, 8'hE1);
    tick = 1'b0;
    check("R9 no request on race", rst_req, 0);
    check("R9 enable kept", ctl_rdata[0], 1);
    ticks(16, s, a);
    check("R9 fresh interval", a, 16);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stopped();
    t_ctl();
    t_locked();
    t_broken();
    ticks(20, checks, checks); checks = checks; // drain running interval
    t_timeout(0);
    t_timeout(3);
    t_timeout(7);
    t_gaps();
    t_restart();
    t_noise();
    t_race();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule